// File: doc/BRIEF.md
# Bounce-Triggered Stereo Sound Timer

This block turns sprite events into a short stereo audio cue. A sprite that hits the left or right screen edge gives a column-bounce pulse, and one that hits the top or bottom edge gives a row-bounce pulse. Either pulse starts a fixed-length cue. For the first half of the cue an incoming 8-bit unsigned sample stream plays on the right channel. For the second half it plays on the left channel. A channel that is not playing holds the mid-scale value 8'h80, which is silent for unsigned audio.

A separate collision pulse opens a timeout window of its own, which runs in parallel with the cue. A status pair records which edge type started the cue that is playing or last played. Both durations are cycle-count parameters. By default the full cue lasts 28,000,000 cycles and the timeout lasts half of that, which is one second at a 14 MHz sample-domain clock.

Top module: `bounce_cue_top`

## Requirements
- R1: While and after a synchronous reset, before any event, left_o and right_o are 8'h80, and bounce_kind_o, sound_active_o and timeout_o are 0.
- R2: On an accepted bounce, bounce_kind_o takes {row, column} of that cycle's pulses: bit 0 means column bounce and bit 1 means row bounce. It holds that value until the next accepted bounce.
- R3: A column or row pulse while no cue is playing starts a cue. sound_active_o rises one cycle later and stays high for exactly CUE_CYCLES cycles.
- R4: For the first CUE_CYCLES/2 cycles of the cue, right_o carries sample_i, delayed by one register stage, and left_o holds 8'h80.
- R5: For the remaining CUE_CYCLES/2 cycles, left_o carries sample_i with the same one-cycle delay, and right_o holds 8'h80.
- R6: Outside a cue (one cycle later than sound_active_o), both channels hold 8'h80.
- R7: A bounce pulse while sound_active_o is high is ignored. This includes a pulse on the last active cycle. The cue is not restarted or lengthened, and bounce_kind_o does not change.
- R8: A collision pulse raises timeout_o on the next cycle for exactly HIT_CYCLES cycles.
- R9: A collision pulse while timeout_o is high restarts the full HIT_CYCLES window from that pulse.
- R10: The two timers are independent. A bounce and a collision in the same cycle both start, and neither timer changes the other's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bounce_col_i | input | 1 | Left/right edge bounce pulse |
| bounce_row_i | input | 1 | Top/bottom edge bounce pulse |
| hit_i | input | 1 | Collision pulse |
| sample_i | input | SAMPLE_W | Unsigned audio sample stream |
| left_o | output | SAMPLE_W | Left channel sample, 8'h80 when silent |
| right_o | output | SAMPLE_W | Right channel sample, 8'h80 when silent |
| bounce_kind_o | output | 2 | Type of the bounce that started the last cue |
| sound_active_o | output | 1 | Cue timer running |
| timeout_o | output | 1 | Collision timeout window open |

## Verification
A bounce and a collision can arrive in the same cycle. A bounce can also arrive on the final active cycle of a cue, when the cue timer is ending and the trigger is still being decided. The bench provokes both cases. It sends a combined bounce and collision pulse and checks that the cue and the timeout open on the same following cycle and then end at their own lengths. It also sends a bounce exactly on the last active cue cycle and expects the cue to end on time with the status unchanged. A scoreboard built from the requirement timelines judges every output in every cycle, so one extra or missing cycle anywhere shows up as a mismatch.

// File: rtl/bounce_cue_pkg.sv
package bounce_cue_pkg;
  typedef enum logic {CH_RIGHT = 1'b0, CH_LEFT = 1'b1} chan_e;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic row;
    logic col;
  } kind_t;

  function automatic int cnt_width(input int len);
    return (len > 1) ? $clog2(len) : 1;
  endfunction
endpackage

// File: rtl/cue_timer.sv
module cue_timer #(
  parameter int LEN    = 16,
  parameter int SPLIT  = LEN / 2,
  parameter bit RETRIG = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic on_o,
  output logic late_o
);
  localparam int CW = bounce_cue_pkg::cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);
  localparam logic [CW-1:0] MID  = CW'(SPLIT);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          load;

  generate
    if (RETRIG) begin : g_retrig
      assign load = start_i;
    end else begin : g_oneshot
      assign load = start_i && !run_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign on_o   = run_q;
  assign late_o = run_q && (cnt_q >= MID);
endmodule

// File: rtl/bounce_capture.sv
module bounce_capture (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 col_i,
  input  logic                 row_i,
  input  logic                 busy_i,
  output logic                 start_o,
  output bounce_cue_pkg::kind_t kind_o
);
  bounce_cue_pkg::kind_t kind_q;

  assign start_o = (col_i || row_i) && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= '0;
    end else if (start_o) begin
      kind_q.col <= col_i;
      kind_q.row <= row_i;
    end
  end

  assign kind_o = kind_q;
endmodule

// File: rtl/channel_router.sv
module channel_router #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                on_i,
  input  logic                late_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  import bounce_cue_pkg::*;
  localparam logic [SAMPLE_W-1:0] SILENCE = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic [NUM_CH-1:0][SAMPLE_W-1:0] chan_q;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic sel;
      assign sel = on_i && (late_i == (ch == int'(CH_LEFT)));
      always_ff @(posedge clk) begin
        if (rst) chan_q[ch] <= SILENCE;
        else     chan_q[ch] <= sel ? sample_i : SILENCE;
      end
    end
  endgenerate

  assign left_o  = chan_q[CH_LEFT];
  assign right_o = chan_q[CH_RIGHT];
endmodule

// File: rtl/bounce_cue_top.sv
module bounce_cue_top #(
  parameter int SAMPLE_W   = 8,
  parameter int CUE_CYCLES = 28_000_000,
  parameter int HIT_CYCLES = CUE_CYCLES / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bounce_col_i,
  input  logic                bounce_row_i,
  input  logic                hit_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic [1:0]          bounce_kind_o,
  output logic                sound_active_o,
  output logic                timeout_o
);
  localparam int HALF = CUE_CYCLES / 2;

  logic                  cue_start;
  logic                  cue_on;
  logic                  cue_late;
  logic                  hit_on;
  logic                  hit_late;
  bounce_cue_pkg::kind_t kind;

  bounce_capture u_cap (
    .clk    (clk),
    .rst    (rst),
    .col_i  (bounce_col_i),
    .row_i  (bounce_row_i),
    .busy_i (cue_on),
    .start_o(cue_start),
    .kind_o (kind)
  );

  cue_timer #(.LEN(CUE_CYCLES), .SPLIT(HALF), .RETRIG(1'b0)) u_cue (
    .clk    (clk),
    .rst    (rst),
    .start_i(cue_start),
    .on_o   (cue_on),
    .late_o (cue_late)
  );

  cue_timer #(.LEN(HIT_CYCLES), .SPLIT(0), .RETRIG(1'b1)) u_hit (
    .clk    (clk),
    .rst    (rst),
    .start_i(hit_i),
    .on_o   (hit_on),
    .late_o (hit_late)
  );

  channel_router #(.SAMPLE_W(SAMPLE_W)) u_route (
    .clk     (clk),
    .rst     (rst),
    .on_i    (cue_on),
    .late_i  (cue_late),
    .sample_i(sample_i),
    .left_o  (left_o),
    .right_o (right_o)
  );

  assign bounce_kind_o  = kind;
  assign sound_active_o = cue_on;
  assign timeout_o      = hit_on || hit_late;
endmodule

// File: rtl/bounce_cue_chk.sv
module bounce_cue_chk #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bounce_col_i,
  input logic                bounce_row_i,
  input logic                hit_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic [1:0]          bounce_kind_o,
  input logic                sound_active_o,
  input logic                timeout_o
);
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!sound_active_o && (bounce_col_i || bounce_row_i)) |=> sound_active_o);

  p_rise_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sound_active_o) |-> $past(bounce_col_i || bounce_row_i));

  p_one_channel_r4: assert property (@(posedge clk) disable iff (rst)
    (left_o == MID) || (right_o == MID));

  p_silent_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!sound_active_o && !$past(sound_active_o)) |-> (left_o == MID && right_o == MID));

  p_kind_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sound_active_o && (bounce_col_i || bounce_row_i)) |=> $stable(bounce_kind_o));

  p_hit_opens_r8: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> timeout_o);

  p_hit_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> $past(hit_i));
endmodule

bind bounce_cue_top bounce_cue_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bounce_col_i  (bounce_col_i),
  .bounce_row_i  (bounce_row_i),
  .hit_i         (hit_i),
  .left_o        (left_o),
  .right_o       (right_o),
  .bounce_kind_o (bounce_kind_o),
  .sound_active_o(sound_active_o),
  .timeout_o     (timeout_o)
);

// File: tb/bounce_cue_top_tb_top.sv
`timescale 1ns/1ps
module bounce_cue_top_tb_top;
  localparam int N = 40;
  localparam int H = N / 2;
  localparam int T = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       col = 1'b0, row = 1'b0, hit = 1'b0;
  logic [7:0] smp = 8'h00;
  logic [7:0] left_o, right_o;
  logic [1:0] kind_o;
  logic       sa_o, to_o;

  always #2.5 clk = ~clk;

  bounce_cue_top #(.SAMPLE_W(8), .CUE_CYCLES(N), .HIT_CYCLES(T)) dut_i (
    .clk(clk), .rst(rst), .bounce_col_i(col), .bounce_row_i(row), .hit_i(hit),
    .sample_i(smp), .left_o(left_o), .right_o(right_o), .bounce_kind_o(kind_o),
    .sound_active_o(sa_o), .timeout_o(to_o));

  typedef struct {
    logic [7:0] l, r;
    logic [1:0] k;
    logic       sa, to;
    string      tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0, errors = 0;
  int    s_age = -1, t_age = -1;
  logic [1:0] kind_m = 2'b00;
  string tag = "R1";
  bit    done = 1'b0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit c, input bit r, input bit h);
    exp_t e;
    bit   s_on;
    @(negedge clk);
    col = c; row = r; hit = h;
    smp = smp * 8'd5 + 8'd17;
    s_on = (s_age >= 0);
    e.r = (s_on && s_age < H)  ? smp : 8'h80;
    e.l = (s_on && s_age >= H) ? smp : 8'h80;
    if (!s_on && (c || r)) begin
      s_age  = 0;
      kind_m = {r, c};
    end else if (s_on) begin
      s_age = (s_age == N - 1) ? -1 : s_age + 1;
    end
    if (h) t_age = 0;
    else if (t_age >= 0) t_age = (t_age == T - 1) ? -1 : t_age + 1;
    e.k = kind_m; e.sa = (s_age >= 0); e.to = (t_age >= 0); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk({"R4 right ", e.tag}, right_o, e.r);
      chk({"R5 left ", e.tag}, left_o, e.l);
      chk({"R2 kind ", e.tag}, {6'd0, kind_o}, {6'd0, e.k});
      chk({"R3 active ", e.tag}, {7'd0, sa_o}, {7'd0, e.sa});
      chk({"R8 timeout ", e.tag}, {7'd0, to_o}, {7'd0, e.to});
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 left", left_o, 8'h80);
    chk("R1 right", right_o, 8'h80);
    chk("R1 kind", {6'd0, kind_o}, 8'h00);
    chk("R1 active", {7'd0, sa_o}, 8'h00);
    chk("R1 timeout", {7'd0, to_o}, 8'h00);
    tag = "R6 idle"; idle(3);
    tag = "R3 column cue"; step(1'b1, 1'b0, 1'b0); idle(44);
    tag = "R7 ignored bounce"; step(1'b0, 1'b1, 1'b0); idle(9);
    step(1'b1, 1'b0, 1'b0); idle(29);
    step(1'b1, 1'b1, 1'b0);          // on the last active cycle
    tag = "R2 both edges"; step(1'b1, 1'b1, 1'b0); idle(42);
    tag = "R9 retrigger"; step(1'b0, 1'b0, 1'b1); idle(9);
    step(1'b0, 1'b0, 1'b1); idle(20);
    tag = "R10 same cycle"; step(1'b1, 1'b0, 1'b1); idle(45);
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule